// File: doc/BRIEF.md
# Burst Shift Clock Enable Controller

This block paces the shift and capture phases of one scan pattern from a single fast reference clock. It does not make clocks; it raises one-cycle enables that a downstream clock gate turns into shift or capture pulses. The bulk of the chain is loaded slowly: a shift enable is issued only once every `slowDiv` reference cycles, and the cycles in between are suppressed. This keeps the switching activity in the scan chains low.

Close to the end of the load, a warm-up ramp narrows the spacing between shift enables by `rampStep` after each shift, never below one cycle. The ramp covers the last `RAMP_LEN` pre-burst shifts. The pattern then ends with a fixed full-rate burst: four shift enables on consecutive cycles, followed at once by one capture enable. A one-cycle `patDone` marks the end of the pattern.

A pattern begins on a single-cycle `startPulse`. The chain length, divide ratio and ramp step are sampled on that pulse and held for the whole pattern.

Top module: `burst_shift_gate`

## Requirements
- R1: After reset, and in every idle cycle, `shiftEn`, `captureEn` and `patDone` are all low.
- R2: The block accepts a `startPulse` only when idle. In the cycle it is accepted, the block samples `chainLen`, `slowDiv` and `rampStep`, using a divide of max(`slowDiv`,2). The first `shiftEn` comes exactly that many cycles after the accepting cycle. Each following pre-ramp shift comes the same number of cycles after the one before.
- R3: A pre-burst shift can leave fewer than `RAMP_LEN` pre-burst shifts still to issue. After such a shift, the gap to the next shift becomes the previous gap minus `rampStep`, or 1 if the subtraction would give less than 1. The first burst shift follows the last pre-burst shift after the current gap.
- R4: The last four `shiftEn` pulses of a pattern fall on consecutive cycles. `captureEn` is high for exactly the single cycle right after the fourth of them.
- R5: A pattern issues exactly max(`chainLen`,4) `shiftEn` pulses. `shiftEn` and `captureEn` are never high in the same cycle.
- R6: `patDone` is high for exactly one cycle, the cycle after `captureEn`. The block is idle from the next cycle on.
- R7: The block is busy from the accepting cycle through the `patDone` cycle. A `startPulse` during that time is ignored, and so are changes to `chainLen`, `slowDiv` or `rampStep`; none of them alter the pattern's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to run a pattern |
| chainLen | input | LEN_W | Shift count per pattern (values below 4 act as 4) |
| slowDiv | input | DIV_W | Reference cycles per slow shift (values below 2 act as 2) |
| rampStep | input | DIV_W | Gap reduction per ramp shift |
| shiftEn | output | 1 | One-cycle shift clock enable |
| captureEn | output | 1 | One-cycle capture clock enable |
| patDone | output | 1 | One-cycle end-of-pattern flag |

## Verification
The properties assume that all inputs are synchronous to `clk` and that reset is held across at least one rising edge before the first pattern. The checks on burst shape and done timing also assume the internal divide clamp holds, so that no shift can land in the cycle right after `patDone`. The stimulus changes inputs only on falling edges. It draws divide values from 0 to 16, so the clamp is exercised, and chain lengths from 0 to 48, so the short-chain floor is covered. It fires stray start strobes and changes the configuration in the middle of a pattern; this exercises the ignore rule without ever overlapping reset.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_CAPTURE,
    PH_FINISH
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // accept a new pattern, sample configuration
    logic fire;   // a shift enable is issued this cycle
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic gapExpired;  // wait counter reached its final cycle
    logic lastShift;   // only one shift left in this pattern
  } dpStatus_t;

endpackage

// File: rtl/burst_gate_datapath.sv
module burst_gate_datapath
  import burst_gate_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int RAMP_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobes,
  input  logic [LEN_W-1:0] chainLen,
  input  logic [DIV_W-1:0] slowDiv,
  input  logic [DIV_W-1:0] rampStep,
  output dpStatus_t        status
);

  localparam int BURST_N = 4;
  localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(BURST_N);
  localparam logic [LEN_W-1:0] BURST_TOP = LEN_W'(BURST_N);
  localparam logic [LEN_W-1:0] RAMP_EDGE = LEN_W'(RAMP_LEN + BURST_N + 1);
  localparam logic [DIV_W-1:0] MIN_DIV   = DIV_W'(2);
  localparam logic [DIV_W-1:0] UNIT_GAP  = DIV_W'(1);

  logic [DIV_W-1:0] waitCnt;
  logic [DIV_W-1:0] curGap;
  logic [DIV_W-1:0] stepReg;
  logic [LEN_W-1:0] remShifts;

  logic [LEN_W-1:0] effLen;
  logic [DIV_W-1:0] effDiv;
  logic             preBurst;
  logic             inRamp;
  logic [DIV_W-1:0] rampedGap;
  logic [DIV_W-1:0] nextGap;

  always_comb begin
    effLen    = (chainLen < MIN_LEN) ? MIN_LEN : chainLen;
    effDiv    = (slowDiv < MIN_DIV) ? MIN_DIV : slowDiv;
    preBurst  = remShifts > BURST_TOP;
    inRamp    = preBurst && (remShifts < RAMP_EDGE);
    rampedGap = (curGap > stepReg) ? (curGap - stepReg) : UNIT_GAP;
    nextGap   = inRamp ? rampedGap : curGap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt   <= '0;
      curGap    <= '0;
      stepReg   <= '0;
      remShifts <= '0;
    end else if (strobes.load) begin
      waitCnt   <= effDiv;
      curGap    <= effDiv;
      stepReg   <= rampStep;
      remShifts <= effLen;
    end else if (strobes.fire) begin
      remShifts <= remShifts - LEN_W'(1);
      curGap    <= nextGap;
      waitCnt   <= preBurst ? nextGap : UNIT_GAP;
    end else if (waitCnt > UNIT_GAP) begin
      waitCnt <= waitCnt - UNIT_GAP;
    end
  end

  assign status.gapExpired = (waitCnt == UNIT_GAP);
  assign status.lastShift  = (remShifts == LEN_W'(1));

endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
  import burst_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobes,
  output logic        shiftEn,
  output logic        captureEn,
  output logic        patDone
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    strobes.load = (phase == PH_IDLE) && startPulse;
    strobes.fire = (phase == PH_SHIFT) && status.gapExpired;
    shiftEn      = strobes.fire;
    captureEn    = (phase == PH_CAPTURE);
    patDone      = (phase == PH_FINISH);
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:    if (startPulse) phaseNext = PH_SHIFT;
      PH_SHIFT:   if (strobes.fire && status.lastShift) phaseNext = PH_CAPTURE;
      PH_CAPTURE: phaseNext = PH_FINISH;
      PH_FINISH:  phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/burst_shift_gate.sv
module burst_shift_gate
  import burst_gate_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int RAMP_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] chainLen,
  input  logic [DIV_W-1:0] slowDiv,
  input  logic [DIV_W-1:0] rampStep,
  output logic             shiftEn,
  output logic             captureEn,
  output logic             patDone
);

  ctrlStrobe_t strobes;
  dpStatus_t   status;

  burst_gate_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .status     (status),
    .strobes    (strobes),
    .shiftEn    (shiftEn),
    .captureEn  (captureEn),
    .patDone    (patDone)
  );

  burst_gate_datapath #(
    .LEN_W    (LEN_W),
    .DIV_W    (DIV_W),
    .RAMP_LEN (RAMP_LEN)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .chainLen (chainLen),
    .slowDiv  (slowDiv),
    .rampStep (rampStep),
    .status   (status)
  );

endmodule

// File: rtl/burst_gate_checker.sv
module burst_gate_checker (
  input logic clk,
  input logic rstN,
  input logic shiftEn,
  input logic captureEn,
  input logic patDone
);

  // R5: shift and capture enables never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftEn && captureEn));

  // R4: capture comes right after four consecutive shifts
  a_r4_burst_tail: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |-> ($past(shiftEn, 1) && $past(shiftEn, 2) &&
                   $past(shiftEn, 3) && $past(shiftEn, 4)));

  // R6: done follows capture in the next cycle
  a_r6_done_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> patDone);

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    patDone |=> !patDone);

  // R1: the cycle after done is idle and quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    patDone |=> (!shiftEn && !captureEn));

  // R6: done is only ever preceded by capture
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(patDone) |-> $past(captureEn));

endmodule

bind burst_shift_gate burst_gate_checker i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .shiftEn   (shiftEn),
  .captureEn (captureEn),
  .patDone   (patDone)
);

// File: tb/test_burst_shift_gate.sv
`timescale 1ns/1ps
module test_burst_shift_gate;

  localparam int LEN_W    = 16;
  localparam int DIV_W    = 8;
  localparam int RAMP_LEN = 8;
  localparam int MAXT     = 1024;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [LEN_W-1:0] chainLen = '0;
  logic [DIV_W-1:0] slowDiv = '0;
  logic [DIV_W-1:0] rampStep = '0;
  logic             shiftEn;
  logic             captureEn;
  logic             patDone;

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 1'b0;

  bit  expS [MAXT];
  int  lastPreAt;
  int  capAt;
  int  doneAt;

  always #2.5 clk = ~clk;

  burst_shift_gate #(
    .LEN_W(LEN_W), .DIV_W(DIV_W), .RAMP_LEN(RAMP_LEN)
  ) i_burst_shift_gate (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .chainLen(chainLen), .slowDiv(slowDiv), .rampStep(rampStep),
    .shiftEn(shiftEn), .captureEn(captureEn), .patDone(patDone)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int effLenOf(input int l);
    return (l < 4) ? 4 : l;
  endfunction

  function automatic int effDivOf(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  // Build the expected schedule from the requirements (R2, R3, R4, R6)
  task automatic buildSchedule(input int l, input int d, input int s);
    int effL = effLenOf(l);
    int gap  = effDivOf(d);
    int t    = 0;
    for (int i = 0; i < MAXT; i++) expS[i] = 1'b0;
    lastPreAt = 0;
    for (int i = 1; i <= effL; i++) begin
      int remB = effL - i + 1;
      int w    = (i > 1 && remB + 1 <= 4) ? 1 : gap;
      t = t + w;
      expS[t] = 1'b1;
      if (remB > 4) begin
        lastPreAt = t;
        if (remB - 5 < RAMP_LEN) gap = (gap > s) ? gap - s : 1;
      end
    end
    capAt  = t + 1;
    doneAt = t + 2;
  endtask

  task automatic runPattern(input int l, input int d, input int s, input int injAt);
    int shiftCnt = 0;
    buildSchedule(l, d, s);
    @(negedge clk);
    chainLen   = LEN_W'(l);
    slowDiv    = DIV_W'(d);
    rampStep   = DIV_W'(s);
    startPulse = 1'b1;
    for (int m = 1; m <= doneAt + 1; m++) begin
      string tagS;
      @(negedge clk);
      startPulse = 1'b0;
      if (m > lastPreAt)      tagS = "R4 burst shift";
      else if (injAt > 0)     tagS = "R2 R3 R7 shift timing";
      else                    tagS = "R2 R3 shift timing";
      check(shiftEn == expS[m], tagS, int'(shiftEn), int'(expS[m]));
      check(captureEn == (m == capAt), "R4 capture timing", int'(captureEn), int'(m == capAt));
      check(patDone == (m == doneAt), "R6 done timing", int'(patDone), int'(m == doneAt));
      check(!(shiftEn && captureEn), "R5 overlap", int'(shiftEn && captureEn), 0);
      if (m == doneAt + 1)
        check(!shiftEn && !captureEn && !patDone, "R1 idle after done",
              int'({shiftEn, captureEn, patDone}), 0);
      if (shiftEn) shiftCnt++;
      if (injAt > 0 && m == injAt) begin
        startPulse = 1'b1;
        chainLen   = LEN_W'($urandom_range(0, 48));
        slowDiv    = DIV_W'($urandom_range(0, 16));
        rampStep   = DIV_W'($urandom_range(0, 7));
      end
    end
    startPulse = 1'b0;
    check(shiftCnt == effLenOf(l), (injAt > 0) ? "R5 R7 shift count" : "R5 shift count",
          shiftCnt, effLenOf(l));
  endtask

  initial begin
    void'($urandom(32'd20161014));
    rstN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!shiftEn && !captureEn && !patDone, "R1 reset state",
            int'({shiftEn, captureEn, patDone}), 0);
    end
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(!shiftEn && !captureEn && !patDone, "R1 idle no strobe",
            int'({shiftEn, captureEn, patDone}), 0);
    end
    // directed corners
    runPattern(4, 2, 0, 0);     // burst only, minimum divide
    runPattern(1, 0, 0, 0);     // clamped length and divide
    runPattern(20, 6, 1, 0);    // gentle ramp
    runPattern(30, 10, 3, 0);   // ramp reaching floor
    runPattern(12, 5, 9, 0);    // step larger than gap
    runPattern(16, 7, 0, 0);    // no ramp
    runPattern(10, 4, 1, 3);    // strobe mid-pattern
    runPattern(5, 3, 1, 0);     // single pre-burst shift
    // random mix
    for (int k = 0; k < 30; k++) begin
      int l   = $urandom_range(0, 48);
      int d   = $urandom_range(0, 16);
      int s   = $urandom_range(0, 7);
      int inj = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 6) : 0;
      runPattern(l, d, s, inj);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        check(!shiftEn && !captureEn && !patDone, "R1 idle gap",
              int'({shiftEn, captureEn, patDone}), 0);
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule